// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Arbiter

This block sits beside a small CPU sequencer and decides which interrupt it should take next. It gathers a reset request, a software-trap request, two external pin interrupts and up to fourteen numbered peripheral slots. It picks the winner by fixed position and hands the sequencer a registered pending flag, a source code and a 16-bit vector address. Vector addresses descend two bytes at a time from the top of the address space, so the sequencer can load its program counter directly from the pair at that address.

The two external pins are edge-detected. Each pin has its own selectable polarity, and the detected edge is latched until the sequencer acknowledges that source. Peripheral lines are level requests that the peripheral holds until software clears its status. A global mask input blocks every numbered source. The reset and trap requests are never masked. A separate wake output tells the clock controller to leave halt mode. Only reset and the external pins may drive it, and they drive it even while the mask is set.

Top module: `irq_vector_arbiter`

## Requirements
- R1: A reset request wins over everything, even with the mask set: one cycle later `irq_pend`=1, `irq_src`=0 and `irq_vec`=16'hFFFE.
- R2: A trap request with no reset request gives `irq_src`=1 and `irq_vec`=16'hFFFC one cycle later. It beats every numbered source and ignores the mask.
- R3: Numbered slot n has code n+2 and vector 16'hFFFA−2n. Among pending slots the lowest n wins. Slots 0 and 1 are the external pins, 2 is clock security, 3 is SPI, 4 is timer A, 6 is timer B and 11 is I²C.
- R4: Slots 5, 7, 8, 9, 10, 12 and 13 never request. The `periph_req` bits 0 and 1 have no effect, because those slots belong to the pins.
- R5: While `i_mask`=1, no numbered source produces `irq_pend`.
- R6: An external pin is latched on the edge its `ext_edge_sel` bit picks (0 = rising, 1 = falling). The latch holds until `ack` is high in a cycle where `irq_pend`=1 and `irq_src` equals that pin's code. An `ack` for a different source leaves the latch set.
- R7: `halt_wake` is 1 one cycle after a reset request, or after any external latch is set, regardless of `i_mask`. Trap and peripheral requests never raise it.
- R8: All outputs are registered. Level inputs show at the outputs one cycle later, and external pin edges show two cycles later. With nothing pending, `irq_pend`=0, `irq_src`=0 and `irq_vec`=0.
- R9: The module reset `rst` clears the latches and all outputs. A pin already at its active level during reset does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high module reset |
| rst_req | input | 1 | Reset interrupt request (highest priority) |
| trap_req | input | 1 | Software trap request |
| i_mask | input | 1 | Global mask for numbered sources |
| ext_pin | input | 2 | External interrupt pins (slots 0 and 1) |
| ext_edge_sel | input | 2 | Per-pin edge select, 0 rising, 1 falling |
| periph_req | input | 14 | Level requests indexed by slot number |
| ack | input | 1 | Acknowledge of the currently presented source |
| irq_pend | output | 1 | A source is pending |
| irq_src | output | 5 | Winning source code (0 reset, 1 trap, n+2 slot n) |
| irq_vec | output | 16 | Vector address of the winner |
| halt_wake | output | 1 | Request to leave halt mode |

## Verification
Level requests (reset, trap, peripherals and the mask) reach the outputs after one register. The bench therefore drives them on a falling edge and samples on the next falling edge. An external pin passes two registers: the edge latch, then the output stage. Pin tests first sample after one edge to confirm nothing has appeared yet, then sample again after the second edge. An acknowledge clears a latch at the edge where it is seen, and the outputs fall one edge after that. Acknowledge checks therefore wait two edges, and they also confirm that a second latched pin then takes over.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int NUM_SRC_D = 14;
    localparam int NUM_EXT_D = 2;
    localparam int CODE_W_D  = 5;
    localparam int VEC_W_D   = 16;

    // Highest vector pair; each code step moves down by two bytes.
    localparam logic [VEC_W_D-1:0] VEC_TOP_D = 16'hFFFE;

    // Numbered slots that have a requester: 0,1,2,3,4,6,11.
    localparam logic [NUM_SRC_D-1:0] LIVE_MASK_D = 14'b00100001011111;

    localparam int CODE_RESET = 0;
    localparam int CODE_TRAP  = 1;
    localparam int CODE_SLOT0 = 2;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_e;

    typedef struct packed {
        logic                pend;
        logic [CODE_W_D-1:0] code;
        logic [VEC_W_D-1:0]  vec;
    } sel_t;

    function automatic logic [VEC_W_D-1:0] vec_of(input logic [CODE_W_D-1:0] c);
        return VEC_TOP_D - (VEC_W_D'(c) << 1);
    endfunction

endpackage

// File: rtl/irqv_edge_latch.sv
module irqv_edge_latch
    import irqv_pkg::*;
#(
    parameter int N_CH = NUM_EXT_D
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] pin,
    input  logic [N_CH-1:0] edge_sel,
    input  logic [N_CH-1:0] clr,
    output logic [N_CH-1:0] pend
);

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic prev_q;
        logic held_q;
        logic hit;

        always_comb begin
            if (edge_e'(edge_sel[ch]) == EDGE_FALL) hit = prev_q & ~pin[ch];
            else                                    hit = ~prev_q & pin[ch];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= pin[ch];
                held_q <= 1'b0;
            end else begin
                prev_q <= pin[ch];
                if (hit)          held_q <= 1'b1;
                else if (clr[ch]) held_q <= 1'b0;
            end
        end

        assign pend[ch] = held_q;
    end

endmodule

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc #(
    parameter int W      = 16,
    parameter int CODE_W = 5
) (
    input  logic [W-1:0]      req,
    output logic              found,
    output logic [CODE_W-1:0] code
);

    always_comb begin
        found = |req;
        code  = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) code = CODE_W'(i);
        end
    end

endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
    import irqv_pkg::*;
#(
    parameter int                   NUM_SRC   = NUM_SRC_D,
    parameter int                   NUM_EXT   = NUM_EXT_D,
    parameter int                   CODE_W    = CODE_W_D,
    parameter logic [NUM_SRC-1:0]   LIVE_MASK = LIVE_MASK_D
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rst_req,
    input  logic               trap_req,
    input  logic               i_mask,
    input  logic [NUM_EXT-1:0] ext_pin,
    input  logic [NUM_EXT-1:0] ext_edge_sel,
    input  logic [NUM_SRC-1:0] periph_req,
    input  logic               ack,
    output logic               irq_pend,
    output logic [CODE_W-1:0]  irq_src,
    output logic [VEC_W_D-1:0] irq_vec,
    output logic               halt_wake
);

    localparam int W = NUM_SRC + 2;
    localparam logic [NUM_SRC-1:0] EXT_SLOTS = NUM_SRC'((1 << NUM_EXT) - 1);

    logic [NUM_EXT-1:0] ext_pend;
    logic [NUM_EXT-1:0] ext_clr;
    logic [NUM_SRC-1:0] ext_wide;
    logic [NUM_SRC-1:0] num_live;
    logic [W-1:0]       req;
    logic               found;
    logic [CODE_W-1:0]  win_code;
    sel_t               sel_q;
    logic               wake_q;

    // An acknowledge retires only the pin that is currently presented.
    for (genvar e = 0; e < NUM_EXT; e++) begin : g_clr
        assign ext_clr[e] = ack && sel_q.pend && (sel_q.code == CODE_W'(e + CODE_SLOT0));
    end

    irqv_edge_latch #(.N_CH(NUM_EXT)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .pin      (ext_pin),
        .edge_sel (ext_edge_sel),
        .clr      (ext_clr),
        .pend     (ext_pend)
    );

    assign ext_wide = NUM_SRC'(ext_pend);
    assign num_live = (ext_wide & EXT_SLOTS) | (periph_req & LIVE_MASK & ~EXT_SLOTS);
    assign req      = {num_live & {NUM_SRC{~i_mask}}, trap_req, rst_req};

    irqv_prio_enc #(.W(W), .CODE_W(CODE_W)) u_enc (
        .req   (req),
        .found (found),
        .code  (win_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            wake_q <= 1'b0;
        end else begin
            sel_q.pend <= found;
            sel_q.code <= found ? win_code : '0;
            sel_q.vec  <= found ? vec_of(win_code) : '0;
            wake_q     <= rst_req | (|ext_pend);
        end
    end

    assign irq_pend  = sel_q.pend;
    assign irq_src   = sel_q.code;
    assign irq_vec   = sel_q.vec;
    assign halt_wake = wake_q;

endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
    parameter int                 NUM_SRC   = 14,
    parameter int                 NUM_EXT   = 2,
    parameter int                 CODE_W    = 5,
    parameter int                 VEC_W     = 16,
    parameter logic [NUM_SRC-1:0] LIVE_MASK = 14'b00100001011111
) (
    input logic               clk,
    input logic               rst,
    input logic               rst_req,
    input logic               trap_req,
    input logic               i_mask,
    input logic               ack,
    input logic [NUM_EXT-1:0] ext_pend,
    input logic               irq_pend,
    input logic [CODE_W-1:0]  irq_src,
    input logic [VEC_W-1:0]   irq_vec,
    input logic               halt_wake
);

    localparam int W  = NUM_SRC + 2;
    localparam int IW = $clog2(W);
    localparam logic [W-1:0] LIVE_CODES = {LIVE_MASK, 2'b11};

    // R1: reset request always wins one cycle later
    p_reset_wins_r1: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> (irq_pend && irq_src == '0 && irq_vec == 16'hFFFE));

    // R2: trap beats numbered sources and ignores the mask
    p_trap_wins_r2: assert property (@(posedge clk) disable iff (rst)
        (trap_req && !rst_req) |=> (irq_pend && irq_src == CODE_W'(1) && irq_vec == 16'hFFFC));

    // R4: no unused slot is ever presented
    p_no_dead_slot_r4: assert property (@(posedge clk) disable iff (rst)
        irq_pend |-> (irq_src < CODE_W'(W)) && LIVE_CODES[irq_src[IW-1:0]]);

    // R5: mask blocks every numbered source
    p_mask_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        (i_mask && !rst_req && !trap_req) |=> !irq_pend);

    // R6: latched edges persist without acknowledge
    p_latch_holds_r6: assert property (@(posedge clk) disable iff (rst)
        !ack |=> ((ext_pend & $past(ext_pend)) == $past(ext_pend)));

    // R7: an external latch wakes from halt regardless of mask
    p_ext_wakes_r7: assert property (@(posedge clk) disable iff (rst)
        (|ext_pend) |=> halt_wake);

    // R7: wake has only reset or external causes
    p_wake_cause_r7: assert property (@(posedge clk) disable iff (rst)
        halt_wake |-> $past(rst_req || (|ext_pend)));

    // R8: idle outputs read zero
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !irq_pend |-> (irq_vec == '0 && irq_src == '0));

endmodule

bind irq_vector_arbiter irqv_checker #(
    .NUM_SRC   (NUM_SRC),
    .NUM_EXT   (NUM_EXT),
    .CODE_W    (CODE_W),
    .VEC_W     (irqv_pkg::VEC_W_D),
    .LIVE_MASK (LIVE_MASK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rst_req   (rst_req),
    .trap_req  (trap_req),
    .i_mask    (i_mask),
    .ack       (ack),
    .ext_pend  (ext_pend),
    .irq_pend  (irq_pend),
    .irq_src   (irq_src),
    .irq_vec   (irq_vec),
    .halt_wake (halt_wake)
);

// File: tb/irq_vector_arbiter_tb.sv
module irq_vector_arbiter_tb;

    localparam time CLK_P = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        rst_req;
    logic        trap_req;
    logic        i_mask;
    logic [1:0]  ext_pin;
    logic [1:0]  ext_edge_sel;
    logic [13:0] periph_req;
    logic        ack;
    logic        irq_pend;
    logic [4:0]  irq_src;
    logic [15:0] irq_vec;
    logic        halt_wake;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_P / 2) clk = ~clk;

    irq_vector_arbiter u_dut (
        .clk          (clk),
        .rst          (rst),
        .rst_req      (rst_req),
        .trap_req     (trap_req),
        .i_mask       (i_mask),
        .ext_pin      (ext_pin),
        .ext_edge_sel (ext_edge_sel),
        .periph_req   (periph_req),
        .ack          (ack),
        .irq_pend     (irq_pend),
        .irq_src      (irq_src),
        .irq_vec      (irq_vec),
        .halt_wake    (halt_wake)
    );

    typedef struct packed {
        logic        r;
        logic        t;
        logic        m;
        logic [13:0] p;
        logic        ep;
        logic [4:0]  es;
        logic [15:0] ev;
        logic        ew;
    } row_t;

    localparam int NROW = 16;
    localparam row_t TBL [NROW] = '{
        '{1'b0, 1'b0, 1'b0, 14'h0000, 1'b0, 5'd0,  16'h0000, 1'b0},
        '{1'b0, 1'b0, 1'b0, 14'h0008, 1'b1, 5'd5,  16'hFFF4, 1'b0},
        '{1'b0, 1'b0, 1'b0, 14'h0808, 1'b1, 5'd5,  16'hFFF4, 1'b0},
        '{1'b0, 1'b0, 1'b0, 14'h0800, 1'b1, 5'd13, 16'hFFE4, 1'b0},
        '{1'b0, 1'b0, 1'b0, 14'h0040, 1'b1, 5'd8,  16'hFFEE, 1'b0},
        '{1'b0, 1'b0, 1'b0, 14'h0020, 1'b0, 5'd0,  16'h0000, 1'b0},
        '{1'b0, 1'b0, 1'b0, 14'h37A0, 1'b0, 5'd0,  16'h0000, 1'b0},
        '{1'b0, 1'b0, 1'b0, 14'h0003, 1'b0, 5'd0,  16'h0000, 1'b0},
        '{1'b0, 1'b0, 1'b0, 14'h0004, 1'b1, 5'd4,  16'hFFF6, 1'b0},
        '{1'b0, 1'b0, 1'b0, 14'h0010, 1'b1, 5'd6,  16'hFFF2, 1'b0},
        '{1'b0, 1'b1, 1'b0, 14'h0004, 1'b1, 5'd1,  16'hFFFC, 1'b0},
        '{1'b1, 1'b1, 1'b0, 14'h0000, 1'b1, 5'd0,  16'hFFFE, 1'b1},
        '{1'b0, 1'b0, 1'b1, 14'h0008, 1'b0, 5'd0,  16'h0000, 1'b0},
        '{1'b0, 1'b1, 1'b1, 14'h0000, 1'b1, 5'd1,  16'hFFFC, 1'b0},
        '{1'b1, 1'b0, 1'b1, 14'h0000, 1'b1, 5'd0,  16'hFFFE, 1'b1},
        '{1'b0, 1'b0, 1'b0, 14'h085C, 1'b1, 5'd4,  16'hFFF6, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_out(input string tag, input logic p, input logic [4:0] s,
                              input logic [15:0] v, input logic w);
        chk({tag, " pend"}, 32'(irq_pend), 32'(p));
        chk({tag, " src"},  32'(irq_src),  32'(s));
        chk({tag, " vec"},  32'(irq_vec),  32'(v));
        chk({tag, " wake"}, 32'(halt_wake), 32'(w));
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_ack();
        ack = 1'b1;
        step(1);
        ack = 1'b0;
        step(1);
    endtask

    initial begin
        #(CLK_P * 5000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; rst_req = 1'b0; trap_req = 1'b0; i_mask = 1'b0;
        ext_pin = 2'b01; ext_edge_sel = 2'b00; periph_req = '0; ack = 1'b0;
        step(3);
        // R9: reset state, pin 0 already high during reset
        expect_out("R9 reset state", 1'b0, 5'd0, 16'h0000, 1'b0);
        rst = 1'b0;
        step(3);
        expect_out("R9 high pin at reset is no edge", 1'b0, 5'd0, 16'h0000, 1'b0);
        ext_pin = 2'b00;
        step(2);

        // Table walk: R1 R2 R3 R4 R5 R7 R8 on level inputs
        for (int i = 0; i < NROW; i++) begin
            rst_req    = TBL[i].r;
            trap_req   = TBL[i].t;
            i_mask     = TBL[i].m;
            periph_req = TBL[i].p;
            step(1);
            expect_out($sformatf("R1 R2 R3 R4 R5 R7 R8 row %0d", i),
                       TBL[i].ep, TBL[i].es, TBL[i].ev, TBL[i].ew);
        end
        rst_req = 1'b0; trap_req = 1'b0; i_mask = 1'b0; periph_req = '0;
        step(2);

        // R8: pin edge needs two cycles; R6 rising latch
        ext_pin[0] = 1'b1;
        step(1);
        chk("R8 pin edge not yet visible", 32'(irq_pend), 32'd0);
        step(1);
        expect_out("R6 rising edge pin0", 1'b1, 5'd2, 16'hFFFA, 1'b1);
        ext_pin[0] = 1'b0;
        step(3);
        expect_out("R6 latch holds after pin low", 1'b1, 5'd2, 16'hFFFA, 1'b1);
        do_ack();
        expect_out("R6 ack clears pin0", 1'b0, 5'd0, 16'h0000, 1'b0);

        // R7: masked pin still wakes; R5 no pending
        i_mask = 1'b1;
        ext_pin[1] = 1'b1;
        step(2);
        expect_out("R7 masked pin1 wakes", 1'b0, 5'd0, 16'h0000, 1'b1);
        i_mask = 1'b0;
        step(1);
        expect_out("R3 unmasked pin1", 1'b1, 5'd3, 16'hFFF8, 1'b1);
        do_ack();
        expect_out("R6 ack clears pin1", 1'b0, 5'd0, 16'h0000, 1'b0);
        ext_pin[1] = 1'b0;
        step(2);

        // R6: falling edge select
        ext_edge_sel[0] = 1'b1;
        ext_pin[0] = 1'b1;
        step(2);
        chk("R6 rise ignored in falling mode", 32'(irq_pend), 32'd0);
        ext_pin[0] = 1'b0;
        step(2);
        expect_out("R6 falling edge pin0", 1'b1, 5'd2, 16'hFFFA, 1'b1);

        // R6: ack retires only the presented pin
        ext_pin[1] = 1'b1;
        step(2);
        chk("R3 pin0 beats pin1", 32'(irq_src), 32'd2);
        do_ack();
        expect_out("R6 pin1 survives ack of pin0", 1'b1, 5'd3, 16'hFFF8, 1'b1);

        // R3: external slot 1 beats clock security slot 2
        periph_req = 14'h0004;
        step(1);
        chk("R3 pin1 over slot2", 32'(irq_src), 32'd3);
        periph_req = '0;
        do_ack();
        expect_out("R6 all clear", 1'b0, 5'd0, 16'h0000, 1'b0);
        ext_pin[1] = 1'b0;
        step(2);

        // R9: reset clears a pending latch
        ext_edge_sel = 2'b00;
        ext_pin[1] = 1'b1;
        step(2);
        chk("R6 pin1 latched before reset", 32'(irq_pend), 32'd1);
        rst = 1'b1;
        step(1);
        expect_out("R9 reset mid-run", 1'b0, 5'd0, 16'h0000, 1'b0);
        rst = 1'b0;
        step(2);
        expect_out("R9 latch gone after reset", 1'b0, 5'd0, 16'h0000, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule